// File: doc/BRIEF.md
# Lane-Segmented Vector ALU

This block is a 128-bit ALU with a single set of operands. A lane-size control divides the word into equal independent lanes of 16, 32, 64 or 128 bits. Add and subtract share one wide adder. The carry is cut at every lane boundary, so each lane wraps on its own and never disturbs its neighbour. Bitwise operations ignore the lane size.

The compare operations give each lane either all ones or all zeros. The signed minimum operation and a mask-driven select let a caller turn a per-lane conditional into a fixed sequence of operations with no branches. A typical sequence is: compare, then select using the compare result as the mask.

Every accepted operation gives a registered result one clock later, flagged by a valid output.

Top module: `simd_seg_alu`

## Requirements
- R1: `lsel` picks the lane layout: 0 gives eight 16-bit lanes, 1 gives four 32-bit lanes, 2 gives two 64-bit lanes, 3 gives one 128-bit lane. Lane i occupies bits [i*L +: L], where L is the lane width.
- R2: Opcode 0 (add) gives each lane (a + b) mod 2^L. No carry crosses a lane boundary.
- R3: Opcode 1 (subtract) gives each lane (a - b) mod 2^L. It is formed as a plus inverted b with a carry-in of 1 at the bottom of each lane, and no borrow crosses a lane boundary.
- R4: Opcodes 2, 3 and 4 give a AND b, a OR b and a XOR b over all 128 bits, whatever the value of `lsel`.
- R5: Opcode 5 (compare equal) sets a lane to all ones when the a and b lanes are equal, and to all zeros otherwise.
- R6: Opcode 6 (compare less) sets a lane to all ones when the a lane is less than the b lane as two's-complement signed values, and to all zeros otherwise.
- R7: Opcode 7 (minimum) gives in each lane the smaller of the a and b lanes, compared as signed values.
- R8: Opcode 8 (select) gives (a AND m) OR (b AND NOT m) on every bit.
- R9: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `in_valid` is low, `res` keeps its value.
- R10: While reset is asserted (`rst_n` low), `out_valid` and `res` are zero.
- R11: Opcodes 9 to 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 4 | Operation code |
| lsel | input | 2 | Lane layout select |
| a | input | 128 | First operand |
| b | input | 128 | Second operand |
| m | input | 128 | Bit mask for select |
| out_valid | output | 1 | Result valid |
| res | output | 128 | Registered result |

## Verification
Any internal fault is visible in `res` in the cycle right after the operation is accepted, because the only state is the output register. A misplaced carry cut shows as a wrong bit at the bottom of the lane above a boundary, and only in the layouts where that boundary exists. A wrong sign or overflow term in the signed compare shows as a whole lane flipping between all ones and all zeros, and as the wrong operand chosen by minimum. Operand pairs that overflow in the lane, that match exactly, and that ripple a carry through every bit expose these faults at once.

// File: rtl/simd_seg_alu.sv
module simd_seg_alu #(
  parameter int DATA_W  = 128,
  parameter int CHUNK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [1:0]        lsel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] m,
  output logic              out_valid,
  output logic [DATA_W-1:0] res
);
  localparam int NCH = DATA_W / CHUNK_W;

  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR  = 4'd3,
                         OP_XOR = 4'd4, OP_EQ  = 4'd5, OP_LT  = 4'd6, OP_MIN = 4'd7,
                         OP_SEL = 4'd8;

  logic              sub_en;
  logic [DATA_W-1:0] b_op;
  logic [DATA_W-1:0] sum;
  logic [NCH-1:0]    eq_raw, lt_top, eq_ch, lt_ch;
  logic [DATA_W-1:0] nxt;
  int                lane_ch;

  assign sub_en = (op == OP_SUB) || (op == OP_LT) || (op == OP_MIN);
  assign b_op   = sub_en ? ~b : b;

  always_comb begin
    lane_ch = 1 << lsel;
    if (lane_ch > NCH) lane_ch = NCH;
  end

  always_comb begin
    logic carry;
    logic cin;
    logic [CHUNK_W:0] part;
    carry = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      cin   = ((k & (lane_ch - 1)) == 0) ? sub_en : carry;
      part  = {1'b0, a[k*CHUNK_W +: CHUNK_W]} + {1'b0, b_op[k*CHUNK_W +: CHUNK_W]}
              + {{CHUNK_W{1'b0}}, cin};
      sum[k*CHUNK_W +: CHUNK_W] = part[CHUNK_W-1:0];
      carry = part[CHUNK_W];
    end
  end

  always_comb begin
    logic as, bs, ds;
    for (int k = 0; k < NCH; k++) begin
      as = a[k*CHUNK_W + CHUNK_W - 1];
      bs = b[k*CHUNK_W + CHUNK_W - 1];
      ds = sum[k*CHUNK_W + CHUNK_W - 1];
      eq_raw[k] = a[k*CHUNK_W +: CHUNK_W] == b[k*CHUNK_W +: CHUNK_W];
      lt_top[k] = (as != bs) ? as : ds;
    end
  end

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      eq_ch[k] = 1'b1;
      for (int j = 0; j < NCH; j++)
        if ((j | (lane_ch - 1)) == (k | (lane_ch - 1)))
          eq_ch[k] = eq_ch[k] & eq_raw[j];
      lt_ch[k] = lt_top[k | (lane_ch - 1)];
    end
  end

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      case (op)
        OP_ADD, OP_SUB: nxt[k*CHUNK_W +: CHUNK_W] = sum[k*CHUNK_W +: CHUNK_W];
        OP_AND: nxt[k*CHUNK_W +: CHUNK_W] = a[k*CHUNK_W +: CHUNK_W] & b[k*CHUNK_W +: CHUNK_W];
        OP_OR:  nxt[k*CHUNK_W +: CHUNK_W] = a[k*CHUNK_W +: CHUNK_W] | b[k*CHUNK_W +: CHUNK_W];
        OP_XOR: nxt[k*CHUNK_W +: CHUNK_W] = a[k*CHUNK_W +: CHUNK_W] ^ b[k*CHUNK_W +: CHUNK_W];
        OP_EQ:  nxt[k*CHUNK_W +: CHUNK_W] = {CHUNK_W{eq_ch[k]}};
        OP_LT:  nxt[k*CHUNK_W +: CHUNK_W] = {CHUNK_W{lt_ch[k]}};
        OP_MIN: nxt[k*CHUNK_W +: CHUNK_W] = lt_ch[k] ? a[k*CHUNK_W +: CHUNK_W]
                                                     : b[k*CHUNK_W +: CHUNK_W];
        OP_SEL: nxt[k*CHUNK_W +: CHUNK_W] = (a[k*CHUNK_W +: CHUNK_W] & m[k*CHUNK_W +: CHUNK_W])
                                          | (b[k*CHUNK_W +: CHUNK_W] & ~m[k*CHUNK_W +: CHUNK_W]);
        default: nxt[k*CHUNK_W +: CHUNK_W] = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res <= nxt;
    end
  end
endmodule

// File: rtl/simd_seg_alu_chk.sv
module simd_seg_alu_chk #(
  parameter int DATA_W  = 128,
  parameter int CHUNK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        op,
  input logic [1:0]        lsel,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic [DATA_W-1:0] m,
  input logic              out_valid,
  input logic [DATA_W-1:0] res
);
  localparam int NCH = DATA_W / CHUNK_W;

  p_valid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res)));

  p_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd2) |=> res == ($past(a) & $past(b)));

  p_xor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd4) |=> res == ($past(a) ^ $past(b)));

  p_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd8) |=> res == (($past(a) & $past(m)) | ($past(b) & ~$past(m))));

  p_equal_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd5 && a == b) |=> (&res));

  p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 4'd8) |=> (res == '0));

  for (genvar k = 0; k < NCH; k++) begin : g_mask
    p_mask_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op == 4'd5 || op == 4'd6)) |=>
        (res[k*CHUNK_W +: CHUNK_W] == '0 || res[k*CHUNK_W +: CHUNK_W] == {CHUNK_W{1'b1}}));
  end
endmodule

bind simd_seg_alu simd_seg_alu_chk #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lsel(lsel),
  .a(a), .b(b), .m(m), .out_valid(out_valid), .res(res)
);

// File: tb/simd_seg_alu_bench.sv
`timescale 1ns/1ps
module simd_seg_alu_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [1:0]   lsel = '0;
  logic [127:0] a = '0, b = '0, m = '0;
  logic         out_valid;
  logic [127:0] res;
  int           total = 0, bad = 0;
  bit           finished = 0;

  always #2 clk = ~clk;

  simd_seg_alu u_simd_seg_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lsel(lsel),
    .a(a), .b(b), .m(m), .out_valid(out_valid), .res(res)
  );

  function automatic logic [127:0] model(input logic [3:0] o, input logic [1:0] s,
                                         input logic [127:0] x, input logic [127:0] y,
                                         input logic [127:0] k);
    int L;
    int n;
    logic [127:0] msk, sb, lx, ly, v, r;
    logic lt;
    L   = 16 << s;
    n   = 128 / L;
    msk = (L == 128) ? {128{1'b1}} : ((128'd1 << L) - 128'd1);
    sb  = 128'd1 << (L - 1);
    r   = '0;
    case (o)
      4'd2: r = x & y;
      4'd3: r = x | y;
      4'd4: r = x ^ y;
      4'd8: r = (x & k) | (y & ~k);
      4'd0, 4'd1, 4'd5, 4'd6, 4'd7: begin
        for (int i = 0; i < n; i++) begin
          lx = (x >> (i * L)) & msk;
          ly = (y >> (i * L)) & msk;
          lt = (lx ^ sb) < (ly ^ sb);
          case (o)
            4'd0: v = (lx + ly) & msk;
            4'd1: v = (lx - ly) & msk;
            4'd5: v = (lx == ly) ? msk : '0;
            4'd6: v = lt ? msk : '0;
            default: v = lt ? lx : ly;
          endcase
          r = r | (v << (i * L));
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%0d lsel=%0d got=%h exp=%h", req, op, lsel, got, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [1:0] s,
                        input logic [127:0] x, input logic [127:0] y, input logic [127:0] k);
    logic [127:0] exp;
    @(negedge clk);
    op = o; lsel = s; a = x; b = y; m = k; in_valid = 1'b1;
    exp = model(o, s, x, y, k);
    @(posedge clk); #1;
    check("R9", {127'd0, out_valid}, 128'd1);
    // R1: every lane layout goes through the same model
    check(req_of(o), res, exp);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R9 watchdog expired got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] pa [9];
    logic [127:0] pb [9];
    logic [127:0] held;
    pa[0] = '0;                 pb[0] = '0;
    pa[1] = {128{1'b1}};        pb[1] = 128'd1;
    pa[2] = {8{16'hFFFF}};      pb[2] = {8{16'h0001}};
    pa[3] = {8{16'h7FFF}};      pb[3] = {8{16'h8000}};
    pa[4] = {8{16'h8000}};      pb[4] = {8{16'h7FFF}};
    pa[5] = {4{32'h8000_0000}}; pb[5] = {4{32'h0000_0001}};
    pa[6] = {2{64'h0123_4567_89AB_CDEF}}; pb[6] = pa[6];
    pa[7] = {16{8'hA5}};        pb[7] = {8{16'hA5A5}} ^ 128'h1;
    pa[8] = 128'h8000_0000_0000_0000_0000_0000_0000_0000; pb[8] = 128'h1;

    #3;
    check("R10", {127'd0, out_valid}, 128'd0);
    check("R10", res, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 16; o++) begin
        for (int p = 0; p < 9; p++)
          run_op(4'(o), 2'(s), pa[p], pb[p], rnd128());
        for (int r = 0; r < 12; r++) begin
          logic [127:0] x;
          x = rnd128();
          run_op(4'(o), 2'(s), x, (r % 3 == 0) ? x : rnd128(), rnd128());
        end
      end
    end

    // R2 and R1: a carry ripples exactly to each lane edge
    run_op(4'd0, 2'd0, {8{16'hFFFF}}, {8{16'h0001}}, '0);
    check("R2", res, 128'd0);
    run_op(4'd0, 2'd3, {8{16'hFFFF}}, 128'd1, '0);
    check("R2", res, 128'd0);
    run_op(4'd1, 2'd1, '0, {4{32'd1}}, '0);
    check("R3", res, {128{1'b1}});

    // R9: idle cycles hold the result and drop valid
    held = res;
    @(negedge clk);
    in_valid = 1'b0; a = rnd128(); b = rnd128(); op = 4'd0;
    @(posedge clk); #1;
    check("R9", {127'd0, out_valid}, 128'd0);
    @(posedge clk); #1;
    check("R9", res, held);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule